// File: doc/BRIEF.md
# Two-Tier Maskable Interrupt Controller

This block collects event pulses from the interrupt sources of a small processor core and turns them into one vector request line. Every source owns a pending flag that latches on a one-cycle pulse. Sources come in two groups. A core source needs two things to reach the processor: the global enable and its own enable bit. A peripheral source needs those two and also a shared group enable. All flags and enables sit in a few registers. Software reads and writes them over a simple register bus with a combinational read port.

The controller never nests handlers. When the processor accepts a request, the controller clears the global enable on the next clock edge. A return-from-interrupt strobe sets the global enable again without any software write. The hardware applies no priority among sources. Software reads the pending flags and chooses which source to serve. Software must also clear each flag it has served. A flag that is still set and enabled when the handler returns raises a new request at once.

Top module: `irq2t_top`

## Requirements
- R1: After reset, all flags are 0, all enables are 0, the global enable is 0, the group enable is 0, and `irqReq` is 0.
- R2: A one-cycle pulse on `coreEvent[i]` or `perEvent[i]` sets flag i on the next clock edge. This happens whether or not the source is enabled, and the flag can then be read on the bus.
- R3: A bus write to a flag register clears every flag whose data bit is 0 and leaves unchanged every flag whose data bit is 1. If a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R4: `irqReq` is a combinational output. It is high when the global enable is 1 and at least one core flag has its enable bit set.
- R5: A set and enabled peripheral flag raises `irqReq` only when both the global enable and the group enable are 1.
- R6: A one-cycle `irqAccept` clears the global enable on the next edge, and `irqReq` then stays low.
- R7: A pulse on `irqReturn` sets the global enable on the next edge. If a flag is still pending and enabled, `irqReq` goes high in that same cycle.
- R8: An event that arrives while the global enable is 0 stays latched and raises a request once the global enable is restored.
- R9: When several sources update the global enable in the same cycle, the priority is fixed: `irqAccept` wins over `irqReturn`, and `irqReturn` wins over a bus write.
- R10: Register map (8-bit data):
  - Address 0 is control. Bit 0 is the global enable and bit 1 is the group enable.
  - Address 1 holds the core enables in bits 2:0 (bit 0 timer overflow, bit 1 external edge, bit 2 port change).
  - Address 2 holds the core flags, with the same bit positions as address 1.
  - Address 3 holds the peripheral enables in bits 6:0.
  - Address 4 holds the peripheral flags, with the same bit positions as address 3.
  - Any other address reads 0 and ignores writes. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreEvent | input | 3 | One-cycle set pulses from the core sources |
| perEvent | input | 7 | One-cycle set pulses from the peripheral sources |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Combinational read data for `busAddr` |
| irqAccept | input | 1 | Processor accepts the request |
| irqReturn | input | 1 | Return-from-interrupt strobe |
| irqReq | output | 1 | Vector request to the processor |

## Verification
The hardest cases to reach from the ports are same-cycle collisions: an event pulse landing on the edge where software clears its flag, and accept, return and a control write all arriving together. The bench drives these inputs at the same falling edge, so they share one rising edge. It then reads the registers back to see which source won. A second hard case is an event that arrives inside a handler. The bench accepts a request, fires a new event while the global enable is low, and checks that the request comes back only after the return strobe.

// File: rtl/irq2t_pkg.sv
package irq2t_pkg;
  // register addresses
  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_CORE_EN  = 1;
  localparam int ADDR_CORE_FLG = 2;
  localparam int ADDR_PER_EN   = 3;
  localparam int ADDR_PER_FLG  = 4;
  // control register bit positions
  localparam int BIT_GLOBAL    = 0;
  localparam int BIT_GROUP     = 1;

  typedef struct packed {
    logic wrCtrl;
    logic wrCoreEn;
    logic wrCoreFlag;
    logic wrPerEn;
    logic wrPerFlag;
  } regStrobe_t;
endpackage

// File: rtl/irq2t_ctrl.sv
module irq2t_ctrl
  import irq2t_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [1:0]        ctrlWData,
  input  logic              irqAccept,
  input  logic              irqReturn,
  input  logic              coreHit,
  input  logic              perHit,
  output regStrobe_t        strb,
  output logic              globalEn,
  output logic              groupEn,
  output logic              irqReq
);

  // address decode into write strobes for the datapath
  always_comb begin
    strb            = '0;
    strb.wrCtrl     = busWrEn && (busAddr == ADDR_W'(ADDR_CTRL));
    strb.wrCoreEn   = busWrEn && (busAddr == ADDR_W'(ADDR_CORE_EN));
    strb.wrCoreFlag = busWrEn && (busAddr == ADDR_W'(ADDR_CORE_FLG));
    strb.wrPerEn    = busWrEn && (busAddr == ADDR_W'(ADDR_PER_EN));
    strb.wrPerFlag  = busWrEn && (busAddr == ADDR_W'(ADDR_PER_FLG));
  end

  // global enable: accept > return > bus write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      groupEn  <= 1'b0;
    end else begin
      if (irqAccept)        globalEn <= 1'b0;
      else if (irqReturn)   globalEn <= 1'b1;
      else if (strb.wrCtrl) globalEn <= ctrlWData[BIT_GLOBAL];
      if (strb.wrCtrl)      groupEn  <= ctrlWData[BIT_GROUP];
    end
  end

  assign irqReq = globalEn && (coreHit || (groupEn && perHit));

  // R6: acceptance closes the gate for the following cycle
  p_accept_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqAccept |=> (!globalEn && !irqReq));

  // R7: a return strobe reopens the gate unless accept collides
  p_return_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqReturn && !irqAccept) |=> globalEn);

  // R9: a bus write cannot override a return strobe
  p_return_over_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqReturn && !irqAccept && strb.wrCtrl && !ctrlWData[BIT_GLOBAL]) |=> globalEn);

endmodule

// File: rtl/irq2t_dpath.sv
module irq2t_dpath
  import irq2t_pkg::*;
#(
  parameter int NUM_CORE = 3,
  parameter int NUM_PER  = 7,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strb,
  input  logic [NUM_CORE-1:0] coreEvent,
  input  logic [NUM_PER-1:0]  perEvent,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWData,
  input  logic                globalEn,
  input  logic                groupEn,
  output logic [DATA_W-1:0]   busRData,
  output logic                coreHit,
  output logic                perHit
);

  logic [NUM_CORE-1:0] coreFlag, coreEn;
  logic [NUM_PER-1:0]  perFlag,  perEn;
  logic                unusedWData;

  assign unusedWData = ^busWData;

  // flag bits: event set wins over a clearing write
  for (genvar i = 0; i < NUM_CORE; i++) begin : g_core
    always_ff @(posedge clk) begin
      if (!rstN) coreFlag[i] <= 1'b0;
      else       coreFlag[i] <= coreEvent[i] ||
                   (coreFlag[i] && !(strb.wrCoreFlag && !busWData[i]));
    end
    // R2: an event pulse always leaves its flag set
    p_core_set_r2: assert property (@(posedge clk) disable iff (!rstN)
      coreEvent[i] |=> coreFlag[i]);
    // R3: a flag only drops after a write to its register
    p_core_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      (coreFlag[i] && !strb.wrCoreFlag) |=> coreFlag[i]);
  end

  for (genvar j = 0; j < NUM_PER; j++) begin : g_per
    always_ff @(posedge clk) begin
      if (!rstN) perFlag[j] <= 1'b0;
      else       perFlag[j] <= perEvent[j] ||
                   (perFlag[j] && !(strb.wrPerFlag && !busWData[j]));
    end
    p_per_set_r2: assert property (@(posedge clk) disable iff (!rstN)
      perEvent[j] |=> perFlag[j]);
    p_per_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      (perFlag[j] && !strb.wrPerFlag) |=> perFlag[j]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreEn <= '0;
      perEn  <= '0;
    end else begin
      if (strb.wrCoreEn) coreEn <= busWData[NUM_CORE-1:0];
      if (strb.wrPerEn)  perEn  <= busWData[NUM_PER-1:0];
    end
  end

  assign coreHit = |(coreFlag & coreEn);
  assign perHit  = |(perFlag & perEn);

  always_comb begin
    busRData = '0;
    case (busAddr)
      ADDR_W'(ADDR_CTRL): begin
        busRData[BIT_GLOBAL] = globalEn;
        busRData[BIT_GROUP]  = groupEn;
      end
      ADDR_W'(ADDR_CORE_EN):  busRData[NUM_CORE-1:0] = coreEn;
      ADDR_W'(ADDR_CORE_FLG): busRData[NUM_CORE-1:0] = coreFlag;
      ADDR_W'(ADDR_PER_EN):   busRData[NUM_PER-1:0]  = perEn;
      ADDR_W'(ADDR_PER_FLG):  busRData[NUM_PER-1:0]  = perFlag;
      default:                busRData = '0;
    endcase
  end

  initial begin
    assert (NUM_CORE <= DATA_W && NUM_PER <= DATA_W && DATA_W >= 2)
      else $error("source count exceeds data width");
  end

endmodule

// File: rtl/irq2t_top.sv
module irq2t_top
  import irq2t_pkg::*;
#(
  parameter int NUM_CORE = 3,
  parameter int NUM_PER  = 7,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CORE-1:0] coreEvent,
  input  logic [NUM_PER-1:0]  perEvent,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWData,
  output logic [DATA_W-1:0]   busRData,
  input  logic                irqAccept,
  input  logic                irqReturn,
  output logic                irqReq
);

  regStrobe_t strb;
  logic       globalEn, groupEn, coreHit, perHit;

  irq2t_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .ctrlWData(busWData[1:0]), .irqAccept(irqAccept), .irqReturn(irqReturn),
    .coreHit(coreHit), .perHit(perHit), .strb(strb),
    .globalEn(globalEn), .groupEn(groupEn), .irqReq(irqReq)
  );

  irq2t_dpath #(.NUM_CORE(NUM_CORE), .NUM_PER(NUM_PER),
                .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .coreEvent(coreEvent),
    .perEvent(perEvent), .busAddr(busAddr), .busWData(busWData),
    .globalEn(globalEn), .groupEn(groupEn), .busRData(busRData),
    .coreHit(coreHit), .perHit(perHit)
  );

endmodule

// File: tb/test_irq2t_top.sv
`timescale 1ns/1ps
module test_irq2t_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] coreEvent = '0;
  logic [6:0] perEvent = '0;
  logic [2:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWData = '0;
  logic [7:0] busRData;
  logic       irqAccept = 1'b0, irqReturn = 1'b0;
  logic       irqReq;

  int total = 0, bad = 0;
  bit done = 0;

  // scoreboard queues: sel 0 = read data, 1 = request line
  int    qSel[$];
  int    qExp[$];
  string qTag[$];
  event  evSample;

  always #2.5 clk = ~clk;

  irq2t_top i_irq2t_top (.*);

  // monitor
  initial forever begin
    int sel, exp, act;
    string tag;
    @(evSample);
    sel = qSel.pop_front(); exp = qExp.pop_front(); tag = qTag.pop_front();
    act = (sel == 0) ? int'(busRData) : int'(irqReq);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  end

  // driver tasks (checks run in the low phase, inputs stable)
  task automatic chkRd(input logic [2:0] a, input int exp, input string tag);
    busAddr = a;
    qSel.push_back(0); qExp.push_back(exp); qTag.push_back(tag);
    #0.5 -> evSample;
    #0.5;
  endtask

  task automatic chkIrq(input int exp, input string tag);
    qSel.push_back(1); qExp.push_back(exp); qTag.push_back(tag);
    #0.5 -> evSample;
    #0.5;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] c, input logic [6:0] p,
                       input logic acc, input logic ret);
    @(negedge clk); coreEvent = c; perEvent = p; irqAccept = acc; irqReturn = ret;
    @(negedge clk); coreEvent = '0; perEvent = '0; irqAccept = 0; irqReturn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 5; a++) chkRd(3'(a), 0, "R1 reset register");
    chkIrq(0, "R1 reset request");

    // R2 flags latch while masked; R10 bit positions
    pulse(3'b101, 7'b1000001, 0, 0);
    chkRd(3'd2, 8'h05, "R2 core flags latched masked");
    chkRd(3'd4, 8'h41, "R2 peripheral flags latched masked");
    chkIrq(0, "R2 no request while masked");

    // R3 write-0 clears, write-1 keeps
    wr(3'd2, 8'hFE);
    chkRd(3'd2, 8'h04, "R3 clear bit0 only");
    wr(3'd2, 8'hFF);
    chkRd(3'd2, 8'h04, "R3 write ones no effect");
    // R3 set wins over same-cycle clear
    @(negedge clk); busAddr = 3'd2; busWData = 8'h00; busWrEn = 1; coreEvent = 3'b010;
    @(negedge clk); busWrEn = 0; coreEvent = '0;
    chkRd(3'd2, 8'h02, "R3 set beats clear");

    // R4 core request
    wr(3'd1, 8'h02);
    chkIrq(0, "R4 no request with global off");
    wr(3'd0, 8'h01);
    chkIrq(1, "R4 core request");
    chkRd(3'd0, 8'h01, "R10 control readback");

    // R5 peripheral needs group enable
    wr(3'd2, 8'h00);
    chkIrq(0, "R4 request drops after clear");
    wr(3'd3, 8'h01);
    chkIrq(0, "R5 peripheral blocked by group enable");
    wr(3'd0, 8'h03);
    chkIrq(1, "R5 peripheral request with group enable");

    // R6 accept
    pulse(3'b000, 7'b0, 1, 0);
    chkIrq(0, "R6 request low after accept");
    chkRd(3'd0, 8'h02, "R6 global cleared");

    // R8 event during handler
    pulse(3'b010, 7'b0, 0, 0);
    chkRd(3'd2, 8'h02, "R8 event latched in handler");
    chkIrq(0, "R8 no nesting");
    wr(3'd4, 8'h00);
    chkRd(3'd4, 8'h00, "R3 peripheral flags cleared");
    // R7 return reopens, pending flag requests immediately
    pulse(3'b000, 7'b0, 0, 1);
    chkRd(3'd0, 8'h03, "R7 global restored");
    chkIrq(1, "R7 R8 pending request after return");

    // R9 priority
    wr(3'd2, 8'h00);
    chkIrq(0, "R3 request gone after clear");
    @(negedge clk); irqAccept = 1; irqReturn = 1;
    busAddr = 3'd0; busWData = 8'h03; busWrEn = 1;
    @(negedge clk); irqAccept = 0; irqReturn = 0; busWrEn = 0;
    chkRd(3'd0, 8'h02, "R9 accept wins");
    @(negedge clk); irqReturn = 1; busAddr = 3'd0; busWData = 8'h02; busWrEn = 1;
    @(negedge clk); irqReturn = 0; busWrEn = 0;
    chkRd(3'd0, 8'h03, "R9 return beats write");

    // R10 unmapped address
    wr(3'd5, 8'hFF);
    chkRd(3'd5, 8'h00, "R10 unmapped reads zero");
    chkRd(3'd0, 8'h03, "R10 unmapped write ignored ctrl");
    chkRd(3'd3, 8'h01, "R10 unmapped write ignored per enable");
    chkRd(3'd1, 8'h02, "R10 core enable bits");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule